// File: doc/BRIEF.md
# Parity-Checking Memory Copy Receiver

This block is the receiving end of a word-by-word memory copy link. On every rising clock edge it looks at a request flag. When the flag is high, a data word and its parity bit are present on the link. The block checks the parity of the word together with its parity bit. A word that passes the check is written through a registered write port into a destination memory and acknowledged. A word that fails is thrown away without acknowledgement, so the sender knows it has to transmit the same word again.

Before a copy starts, a one-cycle start pulse loads the first destination address from an input. Every accepted word advances the write pointer by one. When the word for the last destination address has been written, the block raises a full flag, and the sender uses this flag to stop. A saturating counter of rejected words is exposed, so the number of corrupted words can be seen from outside the block.

Top module: `pcopy_rx`

## Requirements
- R1: While reset is asserted and right after it, `ack`, `mem_we` and `full` are 0 and `perr_cnt` is 0.
- R2: A clock edge with `start` high loads the write pointer from `dst_base`, clears `full` and writes nothing. The next accepted word is written at `dst_base`.
- R3: An edge with `req` low writes nothing and gives no acknowledge, whatever the word and parity inputs hold.
- R4: With the default even mode, a word is valid when `rx_word` and `rx_par` together hold an even number of ones. In the cycle after such an edge, `mem_we` is 1, `mem_addr` is the current pointer and `mem_wdata` is the word.
- R5: `ack` is high for exactly the one cycle after each edge that accepts a word, and it is low in every other cycle.
- R6: A word with an odd total number of ones gives no write and no acknowledge. It leaves the pointer unchanged, so the resent word lands at the same address.
- R7: `perr_cnt` goes up by one for each rejected word. It holds at its all-ones value and does not wrap.
- R8: The pointer advances by exactly one per accepted word and at no other time.
- R9: `full` rises in the cycle after the write to address `LAST_ADDR` (15 by default). It stays high until reset or a start pulse.
- R10: While `full` is high, a request gives no write and no acknowledge, and it does not change `perr_cnt`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Loads the write pointer from dst_base and clears full |
| dst_base | input | AW | First destination address of a copy |
| req | input | 1 | High when a word is present on the link |
| rx_word | input | DW | Received data word |
| rx_par | input | 1 | Received parity bit |
| mem_we | output | 1 | Write strobe to the destination memory |
| mem_addr | output | AW | Write address |
| mem_wdata | output | DW | Write data |
| ack | output | 1 | One-cycle acknowledge of an accepted word |
| full | output | 1 | Last destination address has been written |
| perr_cnt | output | CW | Saturating count of rejected words |

## Verification
A wrong write pointer shows up on `mem_addr` in the first cycle after the next accepted word. A pointer that moves on a rejected word shows up when the resent copy lands one address too high. A wrong full state shows up at `full` in the cycle after the last write. If the full state is lost, a stray `mem_we` and `ack` follow the very next request. A wrong parity decision shows up at once: a valid word is missing its `ack`, or a corrupted word gets one. At the same edge `perr_cnt` also moves when it should not, or fails to move when it should.

// File: rtl/pcopy_pkg.sv
package pcopy_pkg;
   typedef enum logic {PAR_EVEN = 1'b0, PAR_ODD = 1'b1} par_mode_e;
endpackage

// File: rtl/pcopy_parity.sv
module pcopy_parity #(
   parameter int                   DW   = 16,
   parameter pcopy_pkg::par_mode_e MODE = pcopy_pkg::PAR_EVEN
) (
   input  logic [DW-1:0] word,
   input  logic          par,
   output logic          ok
);
   logic ones_odd;
   assign ones_odd = ^{word, par};

   generate
      if (MODE == pcopy_pkg::PAR_EVEN) begin : g_even
         assign ok = ~ones_odd;
      end else begin : g_odd
         assign ok = ones_odd;
      end
   endgenerate
endmodule

// File: rtl/pcopy_dst_ctr.sv
module pcopy_dst_ctr #(
   parameter int AW        = 4,
   parameter int LAST_ADDR = 15
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [AW-1:0] base,
   input  logic          adv,
   output logic [AW-1:0] addr,
   output logic          full
);
   localparam logic [AW-1:0] LAST_A = AW'(LAST_ADDR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr <= '0;
         full <= 1'b0;
      end else if (load) begin
         addr <= base;
         full <= 1'b0;
      end else if (adv) begin
         addr <= addr + 1'b1;
         if (addr == LAST_A) full <= 1'b1;
      end
   end

   AST_FULL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(full) && !$past(load)) |-> full); // R9
   AST_HOLD_NO_ADV: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(adv) && !$past(load)) |-> $stable(addr)); // R8
endmodule

// File: rtl/pcopy_err_ctr.sv
module pcopy_err_ctr #(
   parameter int CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          inc,
   output logic [CW-1:0] cnt
);
   localparam logic [CW-1:0] CMAX = {CW{1'b1}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  cnt <= '0;
      else if (inc && cnt != CMAX) cnt <= cnt + 1'b1;
   end

   AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(cnt) == CMAX) |-> (cnt == CMAX)); // R7
   AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == $past(cnt)) || (cnt == $past(cnt) + 1'b1)); // R7
endmodule

// File: rtl/pcopy_rx.sv
module pcopy_rx #(
   parameter int                   DW        = 16,
   parameter int                   AW        = 4,
   parameter int                   CW        = 8,
   parameter int                   LAST_ADDR = (1 << AW) - 1,
   parameter pcopy_pkg::par_mode_e PAR_MODE  = pcopy_pkg::PAR_EVEN
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [AW-1:0] dst_base,
   input  logic          req,
   input  logic [DW-1:0] rx_word,
   input  logic          rx_par,
   output logic          mem_we,
   output logic [AW-1:0] mem_addr,
   output logic [DW-1:0] mem_wdata,
   output logic          ack,
   output logic          full,
   output logic [CW-1:0] perr_cnt
);
   generate
      if (DW < 1 || AW < 1 || CW < 1) begin : g_bad_width
         $error("pcopy_rx: widths must be positive");
      end
      if (LAST_ADDR < 0 || LAST_ADDR >= (1 << AW)) begin : g_bad_last
         $error("pcopy_rx: LAST_ADDR outside address range");
      end
   endgenerate

   logic          par_ok;
   logic          live;
   logic          accept;
   logic          reject;
   logic [AW-1:0] wr_ptr;

   pcopy_parity #(.DW(DW), .MODE(PAR_MODE)) i_parity (
      .word (rx_word),
      .par  (rx_par),
      .ok   (par_ok)
   );

   assign live   = req && !full && !start;
   assign accept = live && par_ok;
   assign reject = live && !par_ok;

   pcopy_dst_ctr #(.AW(AW), .LAST_ADDR(LAST_ADDR)) i_dst_ctr (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (start),
      .base  (dst_base),
      .adv   (accept),
      .addr  (wr_ptr),
      .full  (full)
   );

   pcopy_err_ctr #(.CW(CW)) i_err_ctr (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (reject),
      .cnt   (perr_cnt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mem_we    <= 1'b0;
         ack       <= 1'b0;
         mem_addr  <= '0;
         mem_wdata <= '0;
      end else begin
         mem_we <= accept;
         ack    <= accept;
         if (accept) begin
            mem_addr  <= wr_ptr;
            mem_wdata <= rx_word;
         end
      end
   end

   AST_ACK_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      ack |-> $past(req)); // R3
   AST_ACK_WITH_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      ack == mem_we); // R5
   AST_NO_WRITE_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(full) && !$past(start)) |-> !mem_we); // R10
   AST_REJECT_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (perr_cnt != $past(perr_cnt)) |-> !mem_we); // R6
   AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && $past(mem_we)) |-> (mem_addr == $past(mem_addr) + 1'b1)); // R8
   AST_FULL_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && mem_addr == AW'(LAST_ADDR)) |-> full); // R9
endmodule

// File: tb/test_pcopy_rx.sv
module test_pcopy_rx;
   localparam int CLK_P = 10;
   localparam int DW    = 16;
   localparam int AW    = 4;
   localparam int CW    = 8;
   localparam int LAST  = 15;

   typedef struct {
      logic          we;
      logic [AW-1:0] addr;
      logic [DW-1:0] data;
      logic          full;
      logic [CW-1:0] perr;
      string         tag;
   } exp_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [AW-1:0] dst_base = '0;
   logic          req = 1'b0;
   logic [DW-1:0] rx_word = '0;
   logic          rx_par = 1'b0;
   logic          mem_we, ack, full;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_wdata;
   logic [CW-1:0] perr_cnt;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;
   exp_t sb[$];

   logic [AW-1:0] m_addr = '0;
   logic          m_full = 1'b0;
   logic [CW-1:0] m_perr = '0;

   pcopy_rx #(.DW(DW), .AW(AW), .CW(CW), .LAST_ADDR(LAST)) i_pcopy_rx (
      .clk(clk), .rst_n(rst_n), .start(start), .dst_base(dst_base),
      .req(req), .rx_word(rx_word), .rx_par(rx_par),
      .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .ack(ack), .full(full), .perr_cnt(perr_cnt)
   );

   always #(CLK_P/2) clk = ~clk;

   task automatic chk(input string tag, input string what, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   function automatic logic good_par(input logic [DW-1:0] w);
      return ^w;
   endfunction

   // driver: one cycle of stimulus, pushes the expected result of that edge
   task automatic cyc(input logic st, input logic [AW-1:0] base, input logic rq,
                      input logic [DW-1:0] w, input logic p, input string tag);
      exp_t e;
      @(negedge clk);
      start = st; dst_base = base; req = rq; rx_word = w; rx_par = p;
      e.we = 1'b0; e.addr = '0; e.data = '0; e.tag = tag;
      if (st) begin
         m_addr = base;
         m_full = 1'b0;
      end else if (rq && !m_full) begin
         if (^{w, p} == 1'b0) begin
            e.we = 1'b1; e.addr = m_addr; e.data = w;
            if (m_addr == AW'(LAST)) m_full = 1'b1;
            m_addr = m_addr + 1'b1;
         end else if (m_perr != {CW{1'b1}}) begin
            m_perr = m_perr + 1'b1;
         end
      end
      e.full = m_full;
      e.perr = m_perr;
      sb.push_back(e);
   endtask

   task automatic good(input logic [DW-1:0] w, input string tag);
      cyc(1'b0, '0, 1'b1, w, good_par(w), tag);
   endtask

   task automatic bad(input logic [DW-1:0] w, input string tag);
      cyc(1'b0, '0, 1'b1, w, ~good_par(w), tag);
   endtask

   task automatic idle(input string tag);
      cyc(1'b0, '0, 1'b0, 16'hA5A5, good_par(16'hA5A5), tag);
   endtask

   // monitor: compares each edge's outputs against the queue
   initial begin
      @(posedge rst_n);
      forever begin
         @(posedge clk);
         #(CLK_P/4);
         if (sb.size() != 0) begin
            exp_t e;
            e = sb.pop_front();
            chk(e.tag, "ack", int'(ack), int'(e.we));
            chk(e.tag, "mem_we", int'(mem_we), int'(e.we));
            if (e.we) begin
               chk(e.tag, "mem_addr", int'(mem_addr), int'(e.addr));
               chk(e.tag, "mem_wdata", int'(mem_wdata), int'(e.data));
            end
            chk(e.tag, "full", int'(full), int'(e.full));
            chk(e.tag, "perr_cnt", int'(perr_cnt), int'(e.perr));
         end
      end
   end

   initial begin
      #(CLK_P * 200000);
      if (!done) begin
         done = 1'b1;
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: outputs during reset
      chk("R1", "ack", int'(ack), 0);
      chk("R1", "mem_we", int'(mem_we), 0);
      chk("R1", "full", int'(full), 0);
      chk("R1", "perr_cnt", int'(perr_cnt), 0);
      rst_n = 1'b1;
      idle("R1");

      // R2: start loads base 3
      cyc(1'b1, 4'd3, 1'b1, 16'h1111, good_par(16'h1111), "R2");
      // R3: req low with a valid-looking word
      idle("R3");
      idle("R3");
      // R4 / R5: valid words of varied patterns
      good(16'h1234, "R4");
      good(16'hFFFF, "R4");
      idle("R5");
      good(16'h0001, "R5");
      good(16'h8000, "R4");
      // R6 / R8: corrupted word then its resend lands at same address
      bad(16'hBEEF, "R6");
      good(16'hBEEF, "R8");
      bad(16'h0000, "R6");
      bad(16'h7FFF, "R6");
      good(16'h7FFF, "R8");

      // R9 / R10: fill from base 13
      cyc(1'b1, 4'd13, 1'b0, '0, 1'b0, "R2");
      good(16'hAAAA, "R9");
      good(16'h5555, "R9");
      good(16'hC3C3, "R9");
      good(16'h0F0F, "R10");
      bad(16'h0F0F, "R10");
      idle("R10");
      good(16'h1357, "R10");
      // R2: start clears full, copy resumes at base 0
      cyc(1'b1, 4'd0, 1'b0, '0, 1'b0, "R2");
      good(16'h2468, "R2");

      // R7: saturation of the reject counter
      for (int i = 0; i < 260; i++) bad(16'(i), "R7");
      good(16'h9999, "R7");
      idle("R5");
      idle("R5");
      @(negedge clk);
      @(negedge clk);
      chk("R5", "queue drained", sb.size(), 0);

      if (!done) begin
         done = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule